// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a synchronous up-counter slice, four bits wide by default. It counts on the rising clock edge. An active-low clear input zeroes it at once, without waiting for a clock edge. An active-low load input copies a parallel data word into it on the next edge.

Counting needs two enables to be high at the same time. The first, `en_p`, is shared by every slice of a chain. The second, `en_t`, comes from the slice below. The terminal output `carry_out` rises only while the slice holds all ones and its own `en_t` is high. It feeds the `en_t` of the next more significant slice, so every slice of a long counter steps on the same edge.

To build a wide counter, tie clock, clear, load and `en_p` to all slices in parallel and chain `carry_out` to `en_t`. The count is always visible on `q`, with bit 0 as the least significant bit.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0 without waiting for a clock edge, and it stays 0 at every edge regardless of `load_n`, `en_p` and `en_t`.
- R2: With `clr_n` high and `load_n` low at a rising edge, `q` takes `d` on that edge (`d[0]` into `q[0]`), whatever the values of `en_p` and `en_t`.
- R3: With `clr_n`, `load_n`, `en_p` and `en_t` all high at a rising edge, `q` becomes its previous value plus one.
- R4: With `clr_n` and `load_n` high and either `en_p` or `en_t` low at a rising edge, `q` keeps its value.
- R5: A counting edge taken while `q` is all ones leaves `q` at 0.
- R6: `carry_out` is high exactly when `q` is all ones and `en_t` is high, combinationally in the same cycle. `en_p` has no effect on it.
- R7: Four slices chained `carry_out` to `en_t`, with clock, clear, load and `en_p` shared, behave as one 16-bit counter with the same load, hold, clear and wrap rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| d | input | WIDTH | Parallel load data |
| en_p | input | 1 | Count enable shared across a chain |
| en_t | input | 1 | Count enable from the lower slice; also gates `carry_out` |
| q | output | WIDTH | Current count, bit 0 least significant |
| carry_out | output | 1 | Terminal count: all ones while `en_t` is high |

## Verification
The count is registered, so a load, count or hold on one edge shows on `q` only after that edge. The bench drives inputs at the falling edge, lets the rising edge pass, and compares `q` at the next falling edge. `carry_out` is combinational, so it is compared one nanosecond after the inputs change, before the next rising edge. The asynchronous clear is compared midway between edges, before any clock edge could explain the change. A reference 16-bit count kept in the bench sweeps the whole range of four chained slices.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic     load_n,
  input  logic     en_p,
  input  logic     en_t,
  output cnt_act_e act
);
  // load outranks counting; both enables are needed to count
  always_comb begin
    if (!load_n)            act = ACT_LOAD;
    else if (en_p && en_t)  act = ACT_COUNT;
    else                    act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_reg.sv
module cnt_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  cnt_act_e         act,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  function automatic logic [WIDTH-1:0] inc_wrap(input logic [WIDTH-1:0] v);
    return v + {{(WIDTH-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (act)
        ACT_LOAD:  q <= d;
        ACT_COUNT: q <= inc_wrap(q);
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             at_max,
  output logic             carry_out
);
  function automatic logic all_ones(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  assign at_max    = all_ones(q);
  assign carry_out = at_max & en_t;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  cnt_act_e act;
  logic     at_max;
  logic     step_evt;
  logic     hold_evt;

  cnt_ctrl u_ctrl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .act    (act)
  );

  cnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .act   (act),
    .d     (d),
    .q     (q)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .q         (q),
    .en_t      (en_t),
    .at_max    (at_max),
    .carry_out (carry_out)
  );

  assign step_evt = load_n && en_p && en_t;
  assign hold_evt = load_n && !(en_p && en_t);

  AST_CLEAR_ZERO: assert property (@(posedge clk) !clr_n |-> q == '0); // R1
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(d)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    step_evt |=> q == WIDTH'($past(q) + ONE)); // R3
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!clr_n)
    hold_evt |=> $stable(q)); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (step_evt && q == FULL) |=> q == '0); // R5
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (en_t && q == FULL)); // R6
  AST_CARRY_PRESENT: assert property (@(posedge clk) disable iff (!clr_n)
    (en_t && at_max) |-> carry_out); // R6
endmodule

// File: tb/cascade_counter_test.sv
`timescale 1ns/1ps
module cascade_counter_test;
  localparam int SW = 4;
  localparam int NS = 4;
  localparam int TW = SW * NS;

  logic          clk = 1'b0;
  logic          clr_n = 1'b1;
  logic          load_n = 1'b1;
  logic [TW-1:0] d = '0;
  logic          en_p = 1'b0;
  logic          en_t0 = 1'b0;
  logic [TW-1:0] q_all;
  logic [NS:0]   chain;

  int compared = 0;
  int mismatched = 0;
  logic [TW-1:0] ref_q = '0;

  always #4 clk = ~clk;

  assign chain[0] = en_t0;

  for (genvar i = 0; i < NS; i++) begin : g_stage
    cascade_counter #(.WIDTH(SW)) uut (
      .clk       (clk),
      .clr_n     (clr_n),
      .load_n    (load_n),
      .d         (d[i*SW +: SW]),
      .en_p      (en_p),
      .en_t      (chain[i]),
      .q         (q_all[i*SW +: SW]),
      .carry_out (chain[i+1])
    );
  end

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, check carries, pass one rising edge, check q.
  task automatic cycle(input logic ld_n, input logic [TW-1:0] dv, input logic ep,
                       input logic et, input string tag);
    load_n = ld_n; d = dv; en_p = ep; en_t0 = et;
    #1;
    chk("R6 slice0 carry", TW'(chain[1]), TW'(et && ref_q[SW-1:0] == {SW{1'b1}}));
    chk("R7 chain carry", TW'(chain[NS]), TW'(et && ref_q == {TW{1'b1}}));
    @(posedge clk);
    if (!ld_n) ref_q = dv;
    else if (ep && et) ref_q = ref_q + 1'b1;
    @(negedge clk);
    chk(tag, q_all, ref_q);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2 clr_n = 1'b0;
    @(negedge clk);
    chk("R1 reset", q_all, '0);
    // clear outranks a pending load with enables high
    load_n = 1'b0; d = 16'h1234; en_p = 1'b1; en_t0 = 1'b1;
    @(negedge clk);
    chk("R1 clear beats load", q_all, '0);
    load_n = 1'b1;
    @(negedge clk);
    chk("R1 clear beats count", q_all, '0);
    clr_n = 1'b1; ref_q = '0;

    cycle(1'b0, 16'hA5C3, 1'b0, 1'b0, "R2 load enables low");
    cycle(1'b1, 16'h0000, 1'b0, 1'b1, "R4 hold en_p low");
    cycle(1'b1, 16'h0000, 1'b1, 1'b0, "R4 hold en_t low");
    cycle(1'b1, 16'h0000, 1'b0, 1'b0, "R4 hold both low");
    cycle(1'b1, 16'h0000, 1'b1, 1'b1, "R3 count");
    cycle(1'b0, 16'h3C5A, 1'b1, 1'b1, "R2 load beats count");
    cycle(1'b0, 16'h0001, 1'b1, 0, "R2 lsb position");

    // slice boundary carries
    cycle(1'b0, 16'h0FFE, 1'b0, 1'b0, "R2 load");
    for (int k = 0; k < 4; k++) cycle(1'b1, '0, 1'b1, 1'b1, "R7 cascade step");
    cycle(1'b0, 16'h00FF, 1'b0, 1'b0, "R2 load");
    cycle(1'b1, '0, 1'b1, 1'b0, "R7 hold when chain en_t low");
    cycle(1'b1, '0, 1'b1, 1'b1, "R7 cascade step");

    // wrap and gated carry
    cycle(1'b0, 16'hFFFE, 1'b0, 1'b0, "R2 load");
    cycle(1'b1, '0, 1'b1, 1'b1, "R3 count to max");
    cycle(1'b1, '0, 1'b1, 1'b0, "R6 carry gated by en_t");
    cycle(1'b1, '0, 1'b0, 1'b1, "R6 carry ignores en_p");
    cycle(1'b1, '0, 1'b1, 1'b1, "R5 wrap to zero");
    chk("R5 wrap value", q_all, '0);

    // full sweep of the 16-bit range
    cycle(1'b0, 16'h0000, 1'b0, 1'b0, "R2 load");
    for (int k = 0; k < 65540; k++) begin
      if (ref_q == 16'hFFFF) cycle(1'b1, '0, 1'b1, 1'b1, "R5 sweep wrap");
      else cycle(1'b1, '0, 1'b1, 1'b1, "R7 sweep count");
    end

    // asynchronous clear midway between edges
    cycle(1'b0, 16'hBEEF, 1'b0, 1'b0, "R2 load");
    #2 clr_n = 1'b0;
    #1;
    chk("R1 async clear", q_all, '0);
    @(negedge clk);
    clr_n = 1'b1; ref_q = '0;
    cycle(1'b1, '0, 1'b1, 1'b1, "R3 count after clear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule